// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block produces the SCL phase timing for an I2C master. A 19-bit control word carries a divisor for the low phase, a divisor for the high phase and a power-of-two prescaler exponent. Each phase lasts its divisor shifted left by the exponent, plus two system clocks. One SCL period is therefore (low divisor + high divisor) x 2^exponent + 4 system clocks. With equal divisors this gives fclk / (2 x div x 2^exp + 4). The usual operating points are 100 kHz, with 400 kHz as the upper limit.

While enabled, the generator runs freely and alternates low and high phases. It gives the byte engine two one-cycle strobes. The sample strobe marks the first cycle of each high phase. The change strobe marks the middle of each low phase. The control word is captured only as a low phase begins, so rewriting it in mid-period cannot shorten a phase. A build option limits the usable exponent to 5.

Top module: `scl_wave_gen`

## Requirements
- R1: The control word fields are: low-phase divisor in bits 7:0, high-phase divisor in bits 15:8, and prescaler exponent in bits 18:16.
- R2: The low phase (scl_o = 0) lasts low_div x 2^exp + 2 system clock cycles.
- R3: The high phase (scl_o = 1) lasts high_div x 2^exp + 2 system clock cycles.
- R4: A divisor of zero is legal and gives a phase of exactly 2 cycles.
- R5: While en_i is low, and after reset, scl_o is 1 and both strobes are 0. In the first cycle after en_i is sampled high, scl_o is 0, which starts a low phase.
- R6: sample_tick_o is 1 for exactly one cycle per period: the first cycle of each high phase.
- R7: change_tick_o is 1 for exactly one cycle per period: low-phase cycle index floor(L/2), counting from 0, where L is the low-phase length.
- R8: The control word is captured only in the cycle a low phase begins. A change at any other point affects nothing until the next low phase begins. A change made in the last high cycle takes effect in the low phase that follows at once.
- R9: With EXP_CLAMP_EN = 1, an exponent above 5 acts as 5. With EXP_CLAMP_EN = 0, all exponents 0 to 7 take effect as written.
- R10: While enabled, the low and high phases alternate with no gap, so each period is the sum of the two phase lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous run enable; low holds SCL released and clears the counter |
| cfg_i | input | 19 | Control word: low divisor, high divisor, exponent |
| scl_o | output | 1 | SCL phase level (0 = low phase, 1 = high or released) |
| sample_tick_o | output | 1 | One-cycle strobe at the start of each high phase |
| change_tick_o | output | 1 | One-cycle strobe at the middle of each low phase |

## Verification
Two events can fall in the same cycle. Capturing the control word at the start of a low phase can coincide with a control-word write. With both divisors zero, the change strobe falls on the last low cycle, which is also the phase transition. The bench provokes the first case by writing the word on the final high cycle and on the first low cycle. It then measures the next two phase lengths and compares them with the old and new arithmetic. The all-zero case is judged by the strobe position and the 2-cycle phase lengths, across an exponent sweep on both the clamped and the unclamped build.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int DIV_W     = 8;
  localparam int EXP_W     = 3;
  localparam int CFG_W     = 2 * DIV_W + EXP_W;
  localparam int SHIFT_MAX = (1 << EXP_W) - 1;
  localparam int LEN_W     = DIV_W + SHIFT_MAX + 1;

  typedef struct packed {
    logic [EXP_W-1:0] shift;
    logic [DIV_W-1:0] hi_div;
    logic [DIV_W-1:0] lo_div;
  } wave_cfg_t;

  typedef logic [LEN_W-1:0] len_t;

  function automatic len_t phase_len(logic [DIV_W-1:0] div, logic [EXP_W-1:0] shift);
    return (len_t'(div) << shift) + len_t'(2);
  endfunction
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
  import scl_gen_pkg::*;
#(
  parameter bit EXP_CLAMP_EN = 1'b0,
  parameter int EXP_LIMIT    = 5
) (
  input  logic [CFG_W-1:0] cfg_i,
  output len_t             low_len_o,
  output len_t             high_len_o
);
  wave_cfg_t        cfg;
  logic [EXP_W-1:0] shift_eff;

  assign cfg = wave_cfg_t'(cfg_i);

  generate
    if (EXP_CLAMP_EN) begin : g_clamp
      assign shift_eff = (cfg.shift > EXP_W'(EXP_LIMIT)) ? EXP_W'(EXP_LIMIT) : cfg.shift;
    end else begin : g_full
      assign shift_eff = cfg.shift;
    end
  endgenerate

  assign low_len_o  = phase_len(cfg.lo_div, shift_eff);
  assign high_len_o = phase_len(cfg.hi_div, shift_eff);
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt
  import scl_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  len_t low_len_i,
  input  len_t high_len_i,
  output logic scl_o,
  output logic sample_tick_o,
  output logic change_tick_o
);
  logic run_q, scl_q;
  len_t cnt_q, lo_q, hi_q;
  logic lo_end, hi_end, low_start;

  assign lo_end    = (cnt_q == lo_q - len_t'(1));
  assign hi_end    = (cnt_q == hi_q - len_t'(1));
  // low phase begins on enable or at the end of a high phase
  assign low_start = en_i && (!run_q || (scl_q && hi_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      scl_q <= 1'b1;
      cnt_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      scl_q <= 1'b1;
      cnt_q <= '0;
    end else if (low_start) begin
      run_q <= 1'b1;
      scl_q <= 1'b0;
      cnt_q <= '0;
      lo_q  <= low_len_i;
      hi_q  <= high_len_i;
    end else if (!scl_q && lo_end) begin
      scl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + len_t'(1);
    end
  end

  assign scl_o         = scl_q;
  assign sample_tick_o = run_q && scl_q && (cnt_q == '0);
  assign change_tick_o = run_q && !scl_q && (cnt_q == (lo_q >> 1));

  // R5
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !sample_tick_o && !change_tick_o && cnt_q == '0));
  // R2
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < (scl_q ? hi_q : lo_q)));
  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !(!scl_q && cnt_q == '0)) |-> ($stable(lo_q) && $stable(hi_q)));
  // R6
  tick_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_tick_o && change_tick_o));
  // R10
  rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(scl_o) && run_q) |-> ($past(cnt_q) == $past(lo_q) - len_t'(1)));
endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_gen_pkg::*;
#(
  parameter bit EXP_CLAMP_EN = 1'b0,
  parameter int EXP_LIMIT    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             scl_o,
  output logic             sample_tick_o,
  output logic             change_tick_o
);
  len_t low_len, high_len;

  scl_cfg_decode #(
    .EXP_CLAMP_EN(EXP_CLAMP_EN),
    .EXP_LIMIT   (EXP_LIMIT)
  ) u_decode (
    .cfg_i     (cfg_i),
    .low_len_o (low_len),
    .high_len_o(high_len)
  );

  scl_phase_cnt u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .low_len_i    (low_len),
    .high_len_i   (high_len),
    .scl_o        (scl_o),
    .sample_tick_o(sample_tick_o),
    .change_tick_o(change_tick_o)
  );
endmodule

// File: tb/scl_wave_gen_test.sv
module scl_wave_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_a = 1'b0, en_b = 1'b0;
  logic [18:0] cfg = '0;
  logic        sel = 1'b0;
  logic        scl_a, smp_a, chg_a, scl_b, smp_b, chg_b;
  logic        scl_m, smp_m, chg_m;
  int          total = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  scl_wave_gen #(.EXP_CLAMP_EN(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_a), .cfg_i(cfg),
    .scl_o(scl_a), .sample_tick_o(smp_a), .change_tick_o(chg_a));

  scl_wave_gen #(.EXP_CLAMP_EN(1'b1)) uut_clamp (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_b), .cfg_i(cfg),
    .scl_o(scl_b), .sample_tick_o(smp_b), .change_tick_o(chg_b));

  assign scl_m = sel ? scl_b : scl_a;
  assign smp_m = sel ? smp_b : smp_a;
  assign chg_m = sel ? chg_b : chg_a;

  function automatic logic [18:0] mk(int lo, int hi, int e);
    return {e[2:0], hi[7:0], lo[7:0]};  // R1 field positions
  endfunction

  task automatic chk(bit ok, string msg, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  // starts at the first low-phase sample, ends at the first low sample of the next period
  task automatic meas(int el, int eh, int sw_ph, int sw_idx, logic [18:0] sw_cfg, string ctx);
    int lo = 0, hi = 0, mid = -1, nmid = 0, nsmp = 0;
    bit first_smp;
    while (scl_m == 1'b0 && lo < 40000) begin
      if (chg_m) begin nmid++; mid = lo; end
      if (smp_m) nsmp++;
      if (sw_ph == 0 && sw_idx == lo) cfg = sw_cfg;
      lo++;
      @(negedge clk);
    end
    first_smp = smp_m;
    while (scl_m == 1'b1 && hi < 40000) begin
      if (smp_m && hi != 0) nsmp++;
      if (chg_m) nmid++;
      if (sw_ph == 1 && sw_idx == hi) cfg = sw_cfg;
      hi++;
      @(negedge clk);
    end
    chk(lo == el, {ctx, " R2 low length"}, lo, el);
    chk(hi == eh, {ctx, " R3 high length"}, hi, eh);
    chk(mid == el / 2 && nmid == 1, {ctx, " R7 change tick index"}, mid, el / 2);
    chk(first_smp && nsmp == 0, {ctx, " R6 sample tick"}, int'(first_smp), 1);
    chk(lo + hi == el + eh, {ctx, " R10 period"}, lo + hi, el + eh);
  endtask

  task automatic run_case(int lo, int hi, int e, bit clamp);
    int ee, el, eh;
    string ctx;
    ee = (clamp && e > 5) ? 5 : e;
    el = lo * (1 << ee) + 2;
    eh = hi * (1 << ee) + 2;
    ctx = $sformatf("lo=%0d hi=%0d e=%0d clamp=%0d", lo, hi, e, clamp);
    @(negedge clk);
    en_a = 1'b0; en_b = 1'b0; sel = clamp;
    cfg = mk(lo, hi, e);
    repeat (3) @(negedge clk);
    chk(scl_m && !smp_m && !chg_m, {ctx, " R5 idle released"}, int'(scl_m), 1);
    if (clamp) en_b = 1'b1; else en_a = 1'b1;
    @(negedge clk);
    chk(scl_m == 1'b0, {ctx, " R5 start low"}, int'(scl_m), 0);
    if (lo == 0) chk(el == 2, {ctx, " R4 zero divisor"}, el, 2);
    if (clamp && e > 5) chk(ee == 5, {ctx, " R9 clamp"}, ee, 5);
    meas(el, eh, -1, -1, '0, ctx);
    meas(el, eh, -1, -1, '0, {ctx, " second"});
    en_a = 1'b0; en_b = 1'b0;
  endtask

  initial begin
    int los[4] = '{0, 1, 3, 5};
    int his[3] = '{0, 2, 7};
    repeat (3) @(negedge clk);
    chk(scl_a && scl_b && !smp_a && !chg_a, "R5 reset state", int'(scl_a), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_a && !smp_a && !chg_a, "R5 disabled after reset", int'(scl_a), 1);

    // R1: distinct fields, distinct lengths
    run_case(3, 7, 0, 1'b0);

    // sweep on the unclamped build (R2 R3 R4 R9)
    for (int e = 0; e < 8; e++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 3; j++)
          run_case(los[i], his[j], e, 1'b0);

    // clamped build (R9)
    for (int e = 0; e < 8; e++) begin
      run_case(1, 2, e, 1'b1);
      run_case(0, 0, e, 1'b1);
    end

    // R8 rewrites in mid-period and on the last high cycle
    @(negedge clk);
    sel = 1'b0; en_b = 1'b0;
    cfg = mk(2, 3, 1);
    en_a = 1'b1;
    @(negedge clk);
    meas(6, 8, 0, 0, mk(5, 1, 1), "R8 write at low start+0");
    meas(12, 4, 1, 3, mk(0, 0, 3), "R8 new word, write on last high");
    meas(2, 2, 1, 0, mk(1, 1, 0), "R8 R4 zero word, write in high");
    meas(3, 3, -1, -1, '0, "R8 after high write");
    en_a = 1'b0;
    @(negedge clk);
    chk(scl_a && !smp_a && !chg_a, "R5 disable mid run", int'(scl_a), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule